// File: doc/BRIEF.md
# Pointer-Pair General Register File

This block holds the working registers of a small 8-bit CPU datapath: thirty-two 8-bit entries. Two read ports are purely combinational and feed the two ALU operands. One registered write port takes the ALU result on the next clock edge. A read, an execute and a writeback therefore fit in one cycle.

The top six entries also form three 16-bit address pointers:

| Pointer | Registers (high:low) | Select code |
|---|---|---|
| X | 27:26 | 0 |
| Y | 29:28 | 1 |
| Z | 31:30 | 2 |

A dedicated pointer port reads any of the three as one word and drives it out as an effective address. It can optionally write the word back after a post-increment or a pre-decrement, with the carry or borrow passing between the two bytes. Z is also driven on its own output at all times, so it can address constant tables in program memory. A byte-wide data-space port maps the registers onto the lowest addresses of a linear map.

Top module: `gpr_file`

## Requirements
- R1: The file holds 32 registers of 8 bits. Ports A and B return the addressed register combinationally. A write on the ALU port (`wrEn`=1) stores `wrData` into `wrAddr` at the next rising edge.
- R2: A read of a register that is being written in the same cycle returns the value held before the edge.
- R3: Pointers are X={r27,r26}, Y={r29,r28} and Z={r31,r30}, with the low byte at the even index. `ptrSel` 0, 1 and 2 pick X, Y and Z. `ptrSel`=3 picks nothing: `ptrAddr` is 0 and no register changes.
- R4: `ptrMode` 0 and 3 leave the selected pointer unchanged, and `ptrAddr` shows its current value.
- R5: `ptrMode`=1 (post-increment) drives the current pointer value on `ptrAddr` and writes back the value plus one, modulo 2^16. Both bytes are written on the same edge.
- R6: `ptrMode`=2 (pre-decrement) drives the pointer value minus one on `ptrAddr` and writes that value back, modulo 2^16 (0x0000 becomes 0xFFFF).
- R7: `zPtr` always equals {r31,r30}.
- R8: A pointer update overrides an ALU or data-space write to either byte of the selected pair in the same cycle. Writes to other registers in that cycle still take effect.
- R9: The data-space port reads and writes register N at address N for addresses 0x00 to 0x1F. For addresses 0x20 and above, `dsRdData` is 0 and writes are ignored.
- R10: When the ALU port and the data-space port write the same register in one cycle, the ALU value is stored.
- R11: A synchronous reset (`rst`=1 at a rising edge) clears all 32 registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Operand A register index |
| rdDataA | output | 8 | Operand A data |
| rdAddrB | input | 5 | Operand B register index |
| rdDataB | output | 8 | Operand B data |
| wrEn | input | 1 | ALU result write enable |
| wrAddr | input | 5 | ALU result register index |
| wrData | input | 8 | ALU result data |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptrMode | input | 2 | 0 none, 1 post-increment, 2 pre-decrement, 3 none |
| ptrAddr | output | 16 | Effective pointer address |
| zPtr | output | 16 | Z pointer value |
| dsAddr | input | 8 | Data-space byte address |
| dsWrEn | input | 1 | Data-space write enable |
| dsWrData | input | 8 | Data-space write data |
| dsRdData | output | 8 | Data-space read data |

## Verification
The pointer properties observe Z through `zPtr` and rely on nothing else writing Z in the cycle of a pointer operation. The exception is a conflicting write, which R8 says must lose. The hold property on Z excludes the cycles in which either byte port targets r30 or r31.

The stimulus changes inputs only one time unit after a rising edge. It samples the combinational outputs before the next edge. It keeps `ptrMode` at zero whenever it expects a register to keep a value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PM_NONE    = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_HOLD    = 2'd3
  } ptrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       aluWe;
    logic       dsWe;
    logic       dsHit;
    logic       ptrWe;
    logic [1:0] ptrIdx;
  } gprStrobe_t;

endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int NUM_PTRS = 3,
  parameter int DS_AW    = 8
) (
  input  logic                             wrEn,
  input  logic                             dsWrEn,
  input  logic [DS_AW-1:0]                 dsAddr,
  input  logic [1:0]                       ptrSel,
  input  logic [1:0]                       ptrMode,
  input  logic [NUM_PTRS-1:0][2*DATA_W-1:0] ptrWords,
  output gprStrobe_t                       strobes,
  output logic [2*DATA_W-1:0]              ptrNext,
  output logic [2*DATA_W-1:0]              ptrAddr
);
  localparam int PTR_W = 2 * DATA_W;

  logic             ptrValid;
  logic [PTR_W-1:0] curPtr;
  logic [PTR_W-1:0] incPtr;
  logic [PTR_W-1:0] decPtr;
  logic             dsHit;

  assign dsHit    = (32'(dsAddr) < NUM_REGS);
  assign ptrValid = (32'(ptrSel) < NUM_PTRS);
  assign curPtr   = ptrValid ? ptrWords[ptrSel] : '0;
  assign incPtr   = curPtr + PTR_W'(1);
  assign decPtr   = curPtr - PTR_W'(1);

  always_comb begin
    strobes.aluWe  = wrEn;
    strobes.dsWe   = dsWrEn && dsHit;
    strobes.dsHit  = dsHit;
    strobes.ptrIdx = ptrSel;
    strobes.ptrWe  = 1'b0;
    ptrNext        = curPtr;
    ptrAddr        = curPtr;
    unique case (ptrMode_e'(ptrMode))
      PM_POSTINC: begin
        ptrNext       = incPtr;
        strobes.ptrWe = ptrValid;
      end
      PM_PREDEC: begin
        ptrNext       = decPtr;
        ptrAddr       = ptrValid ? decPtr : '0;
        strobes.ptrWe = ptrValid;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gpr_data.sv
module gpr_data
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  gprStrobe_t                        strobes,
  input  logic [IDX_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [IDX_W-1:0]                  dsIdx,
  input  logic [DATA_W-1:0]                 dsWrData,
  input  logic [2*DATA_W-1:0]               ptrNext,
  input  logic [IDX_W-1:0]                  rdAddrA,
  input  logic [IDX_W-1:0]                  rdAddrB,
  output logic [DATA_W-1:0]                 rdDataA,
  output logic [DATA_W-1:0]                 rdDataB,
  output logic [DATA_W-1:0]                 dsRdData,
  output logic [NUM_PTRS-1:0][2*DATA_W-1:0] ptrWords
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic              ptrHit;
    logic [DATA_W-1:0] ptrByte;
    if (i >= PTR_BASE && i < PTR_BASE + 2 * NUM_PTRS) begin : g_pair
      localparam int SLOT = (i - PTR_BASE) / 2;
      assign ptrHit  = strobes.ptrWe && (strobes.ptrIdx == 2'(SLOT));
      assign ptrByte = ((i - PTR_BASE) % 2 == 0) ? ptrNext[DATA_W-1:0]
                                                 : ptrNext[2*DATA_W-1:DATA_W];
    end else begin : g_plain
      assign ptrHit  = 1'b0;
      assign ptrByte = '0;
    end

    // pointer beats ALU, ALU beats data space
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (ptrHit)
        regs[i] <= ptrByte;
      else if (strobes.aluWe && wrAddr == IDX_W'(i))
        regs[i] <= wrData;
      else if (strobes.dsWe && dsIdx == IDX_W'(i))
        regs[i] <= dsWrData;
    end
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    assign ptrWords[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  assign rdDataA  = regs[rdAddrA];
  assign rdDataB  = regs[rdAddrB];
  assign dsRdData = strobes.dsHit ? regs[dsIdx] : '0;

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  parameter int DS_AW    = 8,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int PTR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        ptrSel,
  input  logic [1:0]        ptrMode,
  output logic [PTR_W-1:0]  ptrAddr,
  output logic [PTR_W-1:0]  zPtr,
  input  logic [DS_AW-1:0]  dsAddr,
  input  logic              dsWrEn,
  input  logic [DATA_W-1:0] dsWrData,
  output logic [DATA_W-1:0] dsRdData
);
  gprStrobe_t                     strobes;
  logic [PTR_W-1:0]               ptrNext;
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptrWords;

  gpr_ctrl #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_PTRS(NUM_PTRS), .DS_AW(DS_AW)
  ) u_ctrl (
    .wrEn(wrEn), .dsWrEn(dsWrEn), .dsAddr(dsAddr), .ptrSel(ptrSel),
    .ptrMode(ptrMode), .ptrWords(ptrWords), .strobes(strobes),
    .ptrNext(ptrNext), .ptrAddr(ptrAddr)
  );

  gpr_data #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_BASE(PTR_BASE),
    .NUM_PTRS(NUM_PTRS), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .wrAddr(wrAddr), .wrData(wrData),
    .dsIdx(dsAddr[IDX_W-1:0]), .dsWrData(dsWrData), .ptrNext(ptrNext),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA),
    .rdDataB(rdDataB), .dsRdData(dsRdData), .ptrWords(ptrWords)
  );

  assign zPtr = ptrWords[NUM_PTRS-1];

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int PTR_BASE = 26,
  parameter int NUM_PTRS = 3,
  parameter int DS_AW    = 8,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int PTR_W    = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrAddr,
  input logic [1:0]        ptrSel,
  input logic [1:0]        ptrMode,
  input logic [PTR_W-1:0]  ptrAddr,
  input logic [PTR_W-1:0]  zPtr,
  input logic [DS_AW-1:0]  dsAddr,
  input logic              dsWrEn,
  input logic [DATA_W-1:0] dsRdData
);
  localparam int ZLO = PTR_BASE + 2 * (NUM_PTRS - 1);
  localparam logic [1:0] ZSEL = 2'(NUM_PTRS - 1);

  logic zInc, zDec, zTouched;
  assign zInc = (ptrSel == ZSEL) && (ptrMode == 2'd1);
  assign zDec = (ptrSel == ZSEL) && (ptrMode == 2'd2);
  assign zTouched = zInc || zDec
                 || (wrEn && 32'(wrAddr) >= ZLO)
                 || (dsWrEn && 32'(dsAddr) >= ZLO && 32'(dsAddr) < NUM_REGS);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (zPtr == '0 && rdDataA == '0 && rdDataB == '0));

  p_postinc_addr_r5: assert property (@(posedge clk) disable iff (rst)
    zInc |-> ptrAddr == zPtr);

  p_postinc_wb_r5: assert property (@(posedge clk) disable iff (rst)
    zInc |=> zPtr == PTR_W'($past(ptrAddr) + PTR_W'(1)));

  p_predec_addr_r6: assert property (@(posedge clk) disable iff (rst)
    zDec |-> ptrAddr == PTR_W'(zPtr - PTR_W'(1)));

  p_predec_wb_r6: assert property (@(posedge clk) disable iff (rst)
    zDec |=> zPtr == $past(ptrAddr));

  p_unselected_r3: assert property (@(posedge clk) disable iff (rst)
    (ptrSel == 2'd3) |-> ptrAddr == '0);

  p_ds_range_r9: assert property (@(posedge clk) disable iff (rst)
    (32'(dsAddr) >= NUM_REGS) |-> dsRdData == '0);

  p_z_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !zTouched |=> $stable(zPtr));

endmodule

bind gpr_file gpr_file_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_BASE(PTR_BASE),
  .NUM_PTRS(NUM_PTRS), .DS_AW(DS_AW), .IDX_W(IDX_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn),
  .wrAddr(wrAddr), .ptrSel(ptrSel), .ptrMode(ptrMode), .ptrAddr(ptrAddr),
  .zPtr(zPtr), .dsAddr(dsAddr), .dsWrEn(dsWrEn), .dsRdData(dsRdData)
);

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [7:0]  rdDataA, rdDataB, wrData = '0, dsWrData = '0, dsRdData;
  logic        wrEn = 1'b0, dsWrEn = 1'b0;
  logic [1:0]  ptrSel = 2'd3, ptrMode = 2'd0;
  logic [15:0] ptrAddr, zPtr;
  logic [7:0]  dsAddr = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  gpr_file u_gpr_file (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ptrSel(ptrSel), .ptrMode(ptrMode), .ptrAddr(ptrAddr),
    .zPtr(zPtr), .dsAddr(dsAddr), .dsWrEn(dsWrEn), .dsWrData(dsWrData),
    .dsRdData(dsRdData)
  );

  // {address, data} pairs written then read back (R1)
  localparam logic [12:0] VEC [16] = '{
    {5'd0, 8'h3C}, {5'd1, 8'hA5}, {5'd2, 8'h01}, {5'd3, 8'hFE},
    {5'd5, 8'h5E}, {5'd6, 8'h80}, {5'd7, 8'h7F}, {5'd8, 8'hC3},
    {5'd11, 8'h0F}, {5'd12, 8'hF0}, {5'd14, 8'h55}, {5'd15, 8'hAA},
    {5'd17, 8'h12}, {5'd19, 8'hEF}, {5'd21, 8'h64}, {5'd23, 8'h9B}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edgeStep();
    @(posedge clk);
    #1;
  endtask

  task automatic readA(input int idx, output logic [7:0] v);
    rdAddrA = 5'(idx);
    #1;
    v = rdDataA;
  endtask

  task automatic aluWrite(input int idx, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = 5'(idx); wrData = d;
    edgeStep();
    wrEn = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) edgeStep();
    rst = 1'b0;
    #1;
    // R11: every register zero after reset
    for (int i = 0; i < 32; i++) begin
      readA(i, v);
      chk($sformatf("R11 reset reg %0d", i), 16'(v), 16'h0);
    end
    chk("R7 zPtr after reset", zPtr, 16'h0);

    // R1: table writes and dual-port reads
    for (int k = 0; k < 16; k++) aluWrite(int'(VEC[k][12:8]), VEC[k][7:0]);
    for (int k = 0; k < 16; k++) begin
      rdAddrA = VEC[k][12:8];
      rdAddrB = VEC[15-k][12:8];
      #1;
      chk($sformatf("R1 portA entry %0d", k), 16'(rdDataA), 16'(VEC[k][7:0]));
      chk($sformatf("R1 portB entry %0d", k), 16'(rdDataB), 16'(VEC[15-k][7:0]));
    end

    // R2: read during write returns old value
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 8'h99; rdAddrA = 5'd0;
    #1;
    chk("R2 old value during write", 16'(rdDataA), 16'h3C);
    edgeStep();
    wrEn = 1'b0;
    #1;
    chk("R1 new value after write", 16'(rdDataA), 16'h99);

    // R5: post-increment X with carry across bytes
    aluWrite(26, 8'hFF);
    aluWrite(27, 8'h12);
    ptrSel = 2'd0; ptrMode = 2'd1;
    #1;
    chk("R5 postinc X address", ptrAddr, 16'h12FF);
    edgeStep();
    ptrMode = 2'd0;
    readA(26, v); readA(27, v2);
    chk("R5 postinc X written back", {v2, v}, 16'h1300);
    // R4: modes 0 and 3 leave pointer alone
    chk("R4 mode none address", ptrAddr, 16'h1300);
    ptrMode = 2'd3;
    edgeStep();
    chk("R4 mode 3 address", ptrAddr, 16'h1300);
    ptrMode = 2'd0;
    edgeStep();
    readA(26, v); readA(27, v2);
    chk("R4 X unchanged", {v2, v}, 16'h1300);

    // R6: pre-decrement Y wraps 0000 -> FFFF
    ptrSel = 2'd1; ptrMode = 2'd2;
    #1;
    chk("R6 predec Y address", ptrAddr, 16'hFFFF);
    edgeStep();
    ptrMode = 2'd0;
    readA(28, v); readA(29, v2);
    chk("R6 predec Y written back", {v2, v}, 16'hFFFF);
    // R5: post-increment wraps FFFF -> 0000
    ptrMode = 2'd1;
    #1;
    chk("R5 postinc Y address at top", ptrAddr, 16'hFFFF);
    edgeStep();
    ptrMode = 2'd0;
    readA(28, v); readA(29, v2);
    chk("R5 postinc Y wrap", {v2, v}, 16'h0000);

    // R7: Z output follows pair 31:30
    aluWrite(30, 8'h34);
    aluWrite(31, 8'h56);
    chk("R7 zPtr value", zPtr, 16'h5634);

    // R8: pointer update beats ALU write to the same pair
    ptrSel = 2'd2; ptrMode = 2'd1;
    wrEn = 1'b1; wrAddr = 5'd31; wrData = 8'hAA;
    edgeStep();
    wrEn = 1'b0; ptrMode = 2'd0;
    #1;
    chk("R8 pointer wins over ALU", zPtr, 16'h5635);
    // R8: unrelated ALU write in same cycle still lands
    ptrMode = 2'd1;
    wrEn = 1'b1; wrAddr = 5'd4; wrData = 8'h44;
    edgeStep();
    wrEn = 1'b0; ptrMode = 2'd0;
    #1;
    chk("R8 pointer advanced", zPtr, 16'h5636);
    readA(4, v);
    chk("R8 other write lands", 16'(v), 16'h44);
    // R8: pointer beats data-space write to the pair
    ptrMode = 2'd2;
    dsWrEn = 1'b1; dsAddr = 8'd30; dsWrData = 8'hEE;
    edgeStep();
    dsWrEn = 1'b0; ptrMode = 2'd0;
    #1;
    chk("R8 pointer wins over data space", zPtr, 16'h5635);

    // R9: data-space port
    dsAddr = 8'd3;
    #1;
    chk("R9 ds read in range", 16'(dsRdData), 16'hFE);
    dsWrEn = 1'b1; dsAddr = 8'd9; dsWrData = 8'h5A;
    edgeStep();
    dsWrEn = 1'b0;
    readA(9, v);
    chk("R9 ds write in range", 16'(v), 16'h5A);
    dsWrEn = 1'b1; dsAddr = 8'h25; dsWrData = 8'h77;
    edgeStep();
    dsWrEn = 1'b0;
    #1;
    chk("R9 ds read out of range", 16'(dsRdData), 16'h00);
    readA(5, v);
    chk("R9 ds write out of range ignored", 16'(v), 16'h5E);

    // R10: ALU beats data-space on same register
    wrEn = 1'b1; wrAddr = 5'd10; wrData = 8'h11;
    dsWrEn = 1'b1; dsAddr = 8'd10; dsWrData = 8'h22;
    edgeStep();
    wrEn = 1'b0; dsWrEn = 1'b0;
    readA(10, v);
    chk("R10 ALU wins over data space", 16'(v), 16'h11);

    // R3: select 3 gives zero address and no update
    ptrSel = 2'd3; ptrMode = 2'd2;
    #1;
    chk("R3 unselected address", ptrAddr, 16'h0000);
    edgeStep();
    ptrMode = 2'd0;
    #1;
    chk("R3 Z untouched", zPtr, 16'h5635);
    ptrSel = 2'd0;
    #1;
    chk("R3 X untouched", ptrAddr, 16'h1300);
    ptrSel = 2'd1;
    #1;
    chk("R3 Y untouched", ptrAddr, 16'h0000);

    // R11: mid-run synchronous reset
    rst = 1'b1;
    edgeStep();
    rst = 1'b0;
    #1;
    chk("R11 zPtr cleared", zPtr, 16'h0);
    readA(9, v);
    chk("R11 reg 9 cleared", 16'(v), 16'h0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule